// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces horizontal sync, vertical sync, a data-enable strobe and a field flag for a raster display. Software describes each axis with four numbers: the total period, the blanking length, the distance from the start of sync to the first active pixel, and the sync pulse width. It also sets the two sync polarities, a progressive or interlaced select, a small vertical offset for odd fields and a run bit. All of these are written one byte at a time into a shadow register file.

When the run bit is set, a pixel counter and a line counter scan the raster. Every output is decoded from the counters and then registered. Each line and each frame runs in this order: sync pulse, back porch, active region, front porch. The shadow values are copied into the working set only when a frame ends, so software can rewrite the timing while the block is running and never tear a frame. With the run bit cleared, the counters rest at zero and the outputs idle.

Top module: `ext_video_timing`

## Requirements
- R1: After a synchronous active-low reset, `hsync_o` and `vsync_o` are 1, and `de_o` and `field_o` are 0. All shadow fields are zero, which means both polarities are active-low.
- R2: Register addresses. 0x1/0x2 are horizontal total bits [7:0]/[11:8]. 0x3/0x4 are horizontal blank [7:0]/[9:8]. 0x5/0x6 are horizontal delay [7:0]/[9:8]. 0x7/0x8 are horizontal sync width [7:0]/[9:8]. 0x9/0xA are vertical total [7:0]/[9:8]. 0xB, 0xC and 0xD are vertical blank, vertical delay and vertical sync width. Data bits above a field's width in a high-byte write are ignored.
- R3: The settings byte is at address 0x0. Bit 0 is run, bit 1 selects interlace, bit 2 sets HSYNC polarity (1 = active high), bit 3 sets VSYNC polarity (1 = active high), and bits [7:4] hold the odd-field vertical offset.
- R4: The pixel counter counts 0 to htotal-1 and then wraps. HSYNC is active for pixels 0 to hsync-1. The horizontal active window runs from pixel hdelay to pixel htotal-hblank+hdelay-1.
- R5: The line counter advances once per pixel wrap and wraps after vtotal-1. In progressive mode and in even fields, VSYNC is active for lines 0 to vsync-1. The vertical active window runs from line vdelay to line vtotal-vblank+vdelay-1.
- R6: `de_o` is the AND of the horizontal and vertical active windows. All outputs are registered. The outputs for pixel (0,0) appear after the second rising edge that follows the edge capturing the write that sets the run bit.
- R7: A sync output equals its polarity bit while its pulse is active and the inverse of that bit otherwise.
- R8: Within two cycles of the run bit being cleared, the counters are zero, `de_o` and `field_o` are 0, and each sync output sits at its inactive level. The next run starts from pixel (0,0) with field 0.
- R9: Register writes made while running take effect only from the first pixel of the next frame, including polarity changes. The frame in progress is finished with the old values.
- R10: With interlace set, `field_o` toggles at every frame boundary, starting at 0. In odd fields the VSYNC window starts at line voffset instead of line 0. With interlace clear, `field_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| hsync_o | output | 1 | Horizontal sync, polarity as programmed |
| vsync_o | output | 1 | Vertical sync, polarity as programmed |
| de_o | output | 1 | Data enable, high on active pixels |
| field_o | output | 1 | Field flag, 1 during odd fields |

## Verification
The hardest situation to reach from the ports is a retime made while a frame is running. It requires the shadow set to be half-updated, with low bytes new and high bytes not yet written, and a polarity flipped, while the working set stays untouched until the exact frame-end cycle. The bench gets there by enabling a known raster and letting it run two whole frames. At the top of the third frame it then streams a complete new set of values, one byte per cycle, and keeps comparing every pixel against its own model. The model applies the pending values only when it wraps to the next frame. Odd-field offset behaviour is reached by restarting in interlace mode and running three frames, so that an even, an odd and an even field are each observed.

// File: rtl/evt_pkg.sv
// Package: shared widths, register addresses and the timing configuration
// record used by the raster timing generator.
// Assumes every single-byte field fits in DATA_W bits.
package evt_pkg;
    parameter int DATA_W = 8;
    parameter int ADDR_W = 4;
    parameter int HTOT_W = 12;
    parameter int HPAR_W = 10;
    parameter int VTOT_W = 10;
    parameter int VPAR_W = 8;
    parameter int VOFF_W = 4;

    localparam logic [ADDR_W-1:0] A_SETTINGS = 4'h0;
    localparam logic [ADDR_W-1:0] A_HTOT_LO  = 4'h1;
    localparam logic [ADDR_W-1:0] A_HTOT_HI  = 4'h2;
    localparam logic [ADDR_W-1:0] A_HBLK_LO  = 4'h3;
    localparam logic [ADDR_W-1:0] A_HBLK_HI  = 4'h4;
    localparam logic [ADDR_W-1:0] A_HDLY_LO  = 4'h5;
    localparam logic [ADDR_W-1:0] A_HDLY_HI  = 4'h6;
    localparam logic [ADDR_W-1:0] A_HSW_LO   = 4'h7;
    localparam logic [ADDR_W-1:0] A_HSW_HI   = 4'h8;
    localparam logic [ADDR_W-1:0] A_VTOT_LO  = 4'h9;
    localparam logic [ADDR_W-1:0] A_VTOT_HI  = 4'hA;
    localparam logic [ADDR_W-1:0] A_VBLK     = 4'hB;
    localparam logic [ADDR_W-1:0] A_VDLY     = 4'hC;
    localparam logic [ADDR_W-1:0] A_VSW      = 4'hD;

    // Settings byte bit positions (software decodes these)
    localparam int B_RUN   = 0;
    localparam int B_ILACE = 1;
    localparam int B_HPOL  = 2;
    localparam int B_VPOL  = 3;
    localparam int B_VOFF  = 4;

    typedef struct packed {
        logic [HTOT_W-1:0] h_total;
        logic [HPAR_W-1:0] h_blank;
        logic [HPAR_W-1:0] h_delay;
        logic [HPAR_W-1:0] h_sync;
        logic [VTOT_W-1:0] v_total;
        logic [VPAR_W-1:0] v_blank;
        logic [VPAR_W-1:0] v_delay;
        logic [VPAR_W-1:0] v_sync;
        logic [VOFF_W-1:0] v_offset;
        logic              interlace;
        logic              vpol;
        logic              hpol;
        logic              run;
    } timing_cfg_t;
endpackage

// File: rtl/evt_regfile.sv
// Shadow register file: takes byte writes and assembles the timing record.
// Wide fields are split into a low byte and a high byte at separate
// addresses. High-byte data bits beyond a field's width are dropped.
// Assumes one write per cycle; there is no read path.
module evt_regfile
    import evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output timing_cfg_t       shadow
);
    localparam int HTOT_HI_W = HTOT_W - DATA_W;
    localparam int HPAR_HI_W = HPAR_W - DATA_W;
    localparam int VTOT_HI_W = VTOT_W - DATA_W;

    // Purpose: update the addressed shadow field on a write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
        end else if (we) begin
            case (addr)
                A_SETTINGS: begin
                    shadow.run       <= wdata[B_RUN];
                    shadow.interlace <= wdata[B_ILACE];
                    shadow.hpol      <= wdata[B_HPOL];
                    shadow.vpol      <= wdata[B_VPOL];
                    shadow.v_offset  <= wdata[B_VOFF +: VOFF_W];
                end
                A_HTOT_LO: shadow.h_total[DATA_W-1:0]      <= wdata;
                A_HTOT_HI: shadow.h_total[HTOT_W-1:DATA_W] <= wdata[HTOT_HI_W-1:0];
                A_HBLK_LO: shadow.h_blank[DATA_W-1:0]      <= wdata;
                A_HBLK_HI: shadow.h_blank[HPAR_W-1:DATA_W] <= wdata[HPAR_HI_W-1:0];
                A_HDLY_LO: shadow.h_delay[DATA_W-1:0]      <= wdata;
                A_HDLY_HI: shadow.h_delay[HPAR_W-1:DATA_W] <= wdata[HPAR_HI_W-1:0];
                A_HSW_LO:  shadow.h_sync[DATA_W-1:0]       <= wdata;
                A_HSW_HI:  shadow.h_sync[HPAR_W-1:DATA_W]  <= wdata[HPAR_HI_W-1:0];
                A_VTOT_LO: shadow.v_total[DATA_W-1:0]      <= wdata;
                A_VTOT_HI: shadow.v_total[VTOT_W-1:DATA_W] <= wdata[VTOT_HI_W-1:0];
                A_VBLK:    shadow.v_blank                  <= wdata[VPAR_W-1:0];
                A_VDLY:    shadow.v_delay                  <= wdata[VPAR_W-1:0];
                A_VSW:     shadow.v_sync                   <= wdata[VPAR_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/evt_scan.sv
// Raster scanner: pixel and line counters, the working copy of the timing
// record and the field flag. The working copy follows the shadow while
// idle and is reloaded only at the frame-end cycle while running.
// Assumes totals of at least 1.
module evt_scan
    import evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  timing_cfg_t       shadow,
    output timing_cfg_t       act,
    output logic              run,
    output logic [HTOT_W-1:0] h_cnt,
    output logic [VTOT_W-1:0] v_cnt,
    output logic              odd_field
);
    logic h_last;
    logic v_last;

    // Purpose: running needs both the written and the working run bits
    assign run    = shadow.run & act.run;
    assign h_last = (h_cnt >= act.h_total - 1'b1);
    assign v_last = (v_cnt >= act.v_total - 1'b1);

    // Purpose: advance the counters, reload the working set at frame end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cnt     <= '0;
            v_cnt     <= '0;
            odd_field <= 1'b0;
            act       <= '0;
        end else if (!run) begin
            h_cnt     <= '0;
            v_cnt     <= '0;
            odd_field <= 1'b0;
            act       <= shadow;
        end else if (h_last) begin
            h_cnt <= '0;
            if (v_last) begin
                v_cnt     <= '0;
                act       <= shadow;
                odd_field <= shadow.interlace ? ~odd_field : 1'b0;
            end else begin
                v_cnt <= v_cnt + 1'b1;
            end
        end else begin
            h_cnt <= h_cnt + 1'b1;
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (h_cnt == '0 && v_cnt == '0)); // R8
    AST_H_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run && !h_last |=> h_cnt == $past(h_cnt) + 1'b1); // R4
    AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        run && !h_last |=> $stable(v_cnt)); // R5
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        run && !(h_last && v_last) |=> $stable(act)); // R9
    AST_FIELD_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        !act.interlace |-> !odd_field); // R10
endmodule

// File: rtl/evt_decode.sv
// Output decode: turns the counter position and the working timing record
// into sync, data-enable and field levels, and registers all of them.
// Assumes delay >= sync width and blank >= delay, as software guarantees.
module evt_decode
    import evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  timing_cfg_t       act,
    input  logic [HTOT_W-1:0] h_cnt,
    input  logic [VTOT_W-1:0] v_cnt,
    input  logic              odd_field,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              field_o
);
    logic [HTOT_W-1:0] h_act_end;
    logic [VTOT_W-1:0] v_act_end;
    logic [VTOT_W-1:0] v_first;
    logic              h_on;
    logic              v_on;
    logic              h_act;
    logic              v_act;

    // Purpose: window edges derived from total, blank and delay
    always_comb begin
        h_act_end = act.h_total - HTOT_W'(act.h_blank) + HTOT_W'(act.h_delay);
        v_act_end = act.v_total - VTOT_W'(act.v_blank) + VTOT_W'(act.v_delay);
        v_first   = odd_field ? VTOT_W'(act.v_offset) : '0;
        h_on      = (h_cnt < HTOT_W'(act.h_sync));
        v_on      = (v_cnt >= v_first) && (v_cnt < v_first + VTOT_W'(act.v_sync));
        h_act     = (h_cnt >= HTOT_W'(act.h_delay)) && (h_cnt < h_act_end);
        v_act     = (v_cnt >= VTOT_W'(act.v_delay)) && (v_cnt < v_act_end);
    end

    // Purpose: register the outputs, idling at inactive levels when stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_o <= 1'b1;
            vsync_o <= 1'b1;
            de_o    <= 1'b0;
            field_o <= 1'b0;
        end else if (!run) begin
            hsync_o <= ~act.hpol;
            vsync_o <= ~act.vpol;
            de_o    <= 1'b0;
            field_o <= 1'b0;
        end else begin
            hsync_o <= ~(h_on ^ act.hpol);
            vsync_o <= ~(v_on ^ act.vpol);
            de_o    <= h_act & v_act;
            field_o <= odd_field;
        end
    end
endmodule

// File: rtl/ext_video_timing.sv
// Top: programmable raster timing generator. Byte-wide register writes
// fill a shadow set; the scanner and decoder produce registered sync,
// data-enable and field outputs from the working set.
// Assumes a single clock domain for register writes and pixels.
module ext_video_timing
    import evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              field_o
);
    timing_cfg_t       shadow;
    timing_cfg_t       act;
    logic              run;
    logic [HTOT_W-1:0] h_cnt;
    logic [VTOT_W-1:0] v_cnt;
    logic              odd_field;

    evt_regfile u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .shadow (shadow)
    );

    evt_scan u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .shadow    (shadow),
        .act       (act),
        .run       (run),
        .h_cnt     (h_cnt),
        .v_cnt     (v_cnt),
        .odd_field (odd_field)
    );

    evt_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .act       (act),
        .h_cnt     (h_cnt),
        .v_cnt     (v_cnt),
        .odd_field (odd_field),
        .hsync_o   (hsync_o),
        .vsync_o   (vsync_o),
        .de_o      (de_o),
        .field_o   (field_o)
    );

    AST_IDLE_NO_DE: assert property (@(posedge clk) disable iff (!rst_n)
        !shadow.run |=> !de_o && !field_o); // R8
endmodule

// File: tb/ext_video_timing_test.sv
// Directed bench with a pixel-accurate reference model of the raster.
module ext_video_timing_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       hsync_o, vsync_o, de_o, field_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model: pending (written) and current (in use) values
    int p_htot, p_hblk, p_hdly, p_hsw, p_vtot, p_vblk, p_vdly, p_vsw;
    int p_hpol, p_vpol, p_il, p_voff;
    int c_htot, c_hblk, c_hdly, c_hsw, c_vtot, c_vblk, c_vdly, c_vsw;
    int c_hpol, c_vpol, c_il, c_voff;
    int hx, vy, fld;
    bit trk = 0;
    string tag = "R4 R5 R6";
    int cnt_de, cnt_hs, cnt_vs, cnt_fld;

    ext_video_timing uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .de_o(de_o), .field_o(field_o)
    );

    always #5 clk = ~clk;

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic apply_pending();
        c_htot = p_htot; c_hblk = p_hblk; c_hdly = p_hdly; c_hsw = p_hsw;
        c_vtot = p_vtot; c_vblk = p_vblk; c_vdly = p_vdly; c_vsw = p_vsw;
        c_hpol = p_hpol; c_vpol = p_vpol; c_il = p_il; c_voff = p_voff;
    endtask

    // one clock: sample at the falling edge, compare, advance the model
    task automatic step();
        int off, e_hs, e_vs, e_de, hact, vact;
        @(negedge clk);
        if (trk) begin
            off  = fld ? c_voff : 0;
            e_hs = (hx < c_hsw) ? c_hpol : 1 - c_hpol;
            e_vs = (vy >= off && vy < off + c_vsw) ? c_vpol : 1 - c_vpol;
            hact = (hx >= c_hdly && hx < c_htot - c_hblk + c_hdly) ? 1 : 0;
            vact = (vy >= c_vdly && vy < c_vtot - c_vblk + c_vdly) ? 1 : 0;
            e_de = hact & vact;
            chk(tag, $sformatf("pixel(%0d,%0d) {hs,vs,de,fld}", hx, vy),
                {hsync_o, vsync_o, de_o, field_o}, {e_hs[0], e_vs[0], e_de[0], fld[0]});
            cnt_de  += int'(de_o);
            cnt_hs  += int'(hsync_o);
            cnt_vs  += int'(vsync_o);
            cnt_fld += int'(field_o);
            if (hx == c_htot - 1) begin
                hx = 0;
                if (vy == c_vtot - 1) begin
                    vy = 0;
                    apply_pending();
                    fld = c_il ? 1 - fld : 0;
                end else vy++;
            end else hx++;
        end
    endtask

    // register write; the bench decodes its own copy from the R2/R3 map
    task automatic wr(logic [3:0] a, logic [7:0] d);
        case (a)
            4'h0: begin p_il = d[1]; p_hpol = d[2]; p_vpol = d[3]; p_voff = d[7:4]; end
            4'h1: p_htot = (p_htot & 'hF00) | d;
            4'h2: p_htot = (p_htot & 'hFF) | ((d & 'hF) << 8);
            4'h3: p_hblk = (p_hblk & 'h300) | d;
            4'h4: p_hblk = (p_hblk & 'hFF) | ((d & 'h3) << 8);
            4'h5: p_hdly = (p_hdly & 'h300) | d;
            4'h6: p_hdly = (p_hdly & 'hFF) | ((d & 'h3) << 8);
            4'h7: p_hsw = (p_hsw & 'h300) | d;
            4'h8: p_hsw = (p_hsw & 'hFF) | ((d & 'h3) << 8);
            4'h9: p_vtot = (p_vtot & 'h300) | d;
            4'hA: p_vtot = (p_vtot & 'hFF) | ((d & 'h3) << 8);
            4'hB: p_vblk = d;
            4'hC: p_vdly = d;
            4'hD: p_vsw = d;
            default: ;
        endcase
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic load_timing(int ht, int hb, int hd, int hs, int vt, int vb, int vd, int vs,
                               logic [7:0] junk);
        wr(4'h1, 8'(ht)); wr(4'h2, 8'(ht >> 8) | junk);
        wr(4'h3, 8'(hb)); wr(4'h4, 8'(hb >> 8) | junk);
        wr(4'h5, 8'(hd)); wr(4'h6, 8'(hd >> 8) | junk);
        wr(4'h7, 8'(hs)); wr(4'h8, 8'(hs >> 8) | junk);
        wr(4'h9, 8'(vt)); wr(4'hA, 8'(vt >> 8) | junk);
        wr(4'hB, 8'(vb)); wr(4'hC, 8'(vd)); wr(4'hD, 8'(vs));
    endtask

    task automatic start_run(logic [7:0] settings);
        wr(4'h0, settings | 8'h01);
        step();
        apply_pending();
        hx = 0; vy = 0; fld = 0;
        cnt_de = 0; cnt_hs = 0; cnt_vs = 0; cnt_fld = 0;
        trk = 1;
    endtask

    task automatic t_reset();
        chk("R1", "hsync after reset", hsync_o, 1);
        chk("R1", "vsync after reset", vsync_o, 1);
        chk("R1", "de after reset", de_o, 0);
        chk("R1", "field after reset", field_o, 0);
    endtask

    task automatic t_idle_polarity();
        wr(4'h0, 8'b0000_0100);  // hpol=1 vpol=0, stopped
        repeat (3) step();
        chk("R7 R8", "idle hsync, active-high", hsync_o, 0);
        chk("R7 R8", "idle vsync, active-low", vsync_o, 1);
        wr(4'h0, 8'b0000_1000);
        repeat (3) step();
        chk("R7 R8", "idle hsync, active-low", hsync_o, 1);
        chk("R7 R8", "idle vsync, active-high", vsync_o, 0);
        chk("R8", "idle de", de_o, 0);
    endtask

    task automatic t_progressive();
        // h: sync 3, bp 2, active 6, fp 2; v: sync 2, bp 1, active 3, fp 1
        // junk in high bytes must be ignored (R2)
        load_timing(13, 7, 5, 3, 7, 4, 3, 2, 8'hF0);
        tag = "R2 R3 R4 R5 R6 R7";
        start_run(8'b0000_1100);
        repeat (91) step();
        chk("R6", "de cycles per frame", cnt_de, 18);
        chk("R4", "hsync cycles per frame", cnt_hs, 21);
        chk("R5", "vsync cycles per frame", cnt_vs, 26);
        repeat (91) step();
    endtask

    task automatic t_retime();
        // issued at the top of the third frame; old frame must finish intact
        tag = "R9 R7";
        wr(4'h0, 8'b0000_1001);            // hpol 0, vpol 1, keep running
        load_timing(10, 6, 4, 2, 6, 3, 2, 1, 8'h00);
        repeat (91 - 14) step();
        chk("R9", "model at new frame start", hx + vy, 0);
        cnt_de = 0;
        repeat (60) step();
        chk("R9", "de cycles in retimed frame", cnt_de, 12);
        repeat (60) step();
    endtask

    task automatic t_stop();
        trk = 0;
        wr(4'h0, 8'b0000_1000);            // hpol 0, vpol 1, stop
        repeat (2) step();
        chk("R8", "stopped hsync inactive", hsync_o, 1);
        chk("R8", "stopped vsync inactive", vsync_o, 0);
        chk("R8", "stopped de", de_o, 0);
        chk("R8", "stopped field", field_o, 0);
        repeat (20) step();
        chk("R8", "still idle de", de_o, 0);
        chk("R8", "still idle hsync", hsync_o, 1);
    endtask

    task automatic t_interlace();
        tag = "R10 R8 R5";
        start_run(8'b0010_1110);           // voff 2, vpol 1, hpol 1, interlace
        repeat (180) step();
        chk("R10", "odd-field cycles over three fields", cnt_fld, 60);
        chk("R10", "vsync cycles over three fields", cnt_vs, 30);
    endtask

    initial begin
        p_htot = 0; p_hblk = 0; p_hdly = 0; p_hsw = 0; p_vtot = 0; p_vblk = 0;
        p_vdly = 0; p_vsw = 0; p_hpol = 0; p_vpol = 0; p_il = 0; p_voff = 0;
        apply_pending();
        hx = 0; vy = 0; fld = 0;
        repeat (4) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_idle_polarity();
        t_progressive();
        t_retime();
        t_stop();
        t_interlace();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (R1 to R10 pending): actual >=20000 cycles expected fewer");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule